// File: doc/BRIEF.md
# Interval Timer Host Bus Front End

This block sits between a CPU bus and three interval-timer channels. It accepts an active-low chip select with active-low read and write strobes, a 2-bit address and an 8-bit data byte. From these it produces single-cycle command strobes for the channels. The strobes carry every field that a channel needs to act, so the channel does not have to decode the bus itself. The counting logic and the output waveforms live in the channels.

Address values 0, 1 and 2 select a channel, and value 3 selects the command port. A byte written to a channel address becomes a count-byte strobe to that channel. A byte written to the command port is decoded into one of three kinds of command:
- a mode write to one channel;
- a count snapshot request for one channel;
- a multi-channel read-back command, which can request count snapshots, status snapshots, or both.

A read from a channel address drives that channel's read byte onto the bus, with the output enable raised. When the read ends, the block sends a read-done pulse to that channel.

All strobes on the bus are sampled on the system clock. A command acts on the trailing edge of its strobe, using the address and data that were captured while the strobe was active. Each command strobe is registered and lasts exactly one cycle.

Top module: `tmr_bus_front`

## Requirements
- R1: A write completed at address 0, 1 or 2 raises `cnt_wr` bit equal to the address, with `cnt_byte` equal to the data written, for one cycle.
- R2: While `cs_n` is high, read and write strobes have no effect: no strobe is produced and `bus_oe` stays low.
- R3: While `cs_n` and `rd_n` are low and `wr_n` is high, `bus_oe` is high and `bus_out` equals byte `addr` of `ch_rdata` (bits 8*a+7 down to 8*a) for addresses 0 to 2. At address 3, `bus_oe` stays low.
- R4: With `rd_n` and `wr_n` both low, or both high, nothing happens: no strobe is produced and `bus_oe` is low.
- R5: A command byte (address 3) whose bits 7:6 hold a channel number n (0 to 2), and whose bits 5:4 are not 00, raises only `mode_wr[n]`. With it, `mode_fmt` equals bits 5:4 and `mode_bcd` equals bit 0.
- R6: `mode_code` equals bits 3:1 of the command byte, except that codes 110 and 111 are reported as 010 and 011.
- R7: A command byte with bits 7:6 = n (0 to 2) and bits 5:4 = 00 raises only `latch_cnt[n]`. No mode write is produced.
- R8: A command byte with bits 7:6 = 11 is a read-back command. Bit k+1 set selects channel k. For every selected channel, bit 5 = 0 raises `latch_cnt`, and bit 4 = 0 raises `latch_sts`, both in the same cycle. Bit 0 has no effect.
- R9: Each write produces exactly one strobe cycle. That cycle follows the clock edge at which the ended write is first seen inactive.
- R10: A completed read at address 0 to 2 raises `rd_done[addr]` for one cycle, on the same timing as R9. A read at address 3 produces no pulse.
- R11: A synchronous reset clears every strobe output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Channel (0 to 2) or command port (3) |
| bus_in | input | 8 | Write data from the bus |
| bus_out | output | 8 | Read data to the bus |
| bus_oe | output | 1 | Output enable for the tri-state bus driver |
| ch_rdata | input | 24 | Read bytes of the three channels, channel 0 in the low byte |
| mode_wr | output | 3 | Mode write strobe, one bit per channel |
| mode_fmt | output | 2 | Byte access format that goes with the mode write |
| mode_code | output | 3 | Folded mode number |
| mode_bcd | output | 1 | Decimal counting select |
| cnt_wr | output | 3 | Count byte write strobe, one bit per channel |
| cnt_byte | output | 8 | Count byte that goes with `cnt_wr` |
| latch_cnt | output | 3 | Count snapshot request, one bit per channel |
| latch_sts | output | 3 | Status snapshot request, one bit per channel |
| rd_done | output | 3 | Read completed pulse, one bit per channel |

## Verification
The read path has no registers, so `bus_out` and `bus_oe` are due in the same cycle the inputs change. The bench compares them at the falling edge after it drives the bus. Every strobe takes two clock edges to appear: one edge samples the strobe as inactive, and the same edge registers the command. So the strobe is visible in the half cycle after that edge. The bench's behavioural model steps once per rising edge and predicts exactly that cycle. The bench compares the outputs with the model on every falling edge, so a strobe that comes a cycle early or late, or arrives twice, is caught.

// File: rtl/tmr_bus_pkg.sv
package tmr_bus_pkg;
    localparam int unsigned NCH = 3;
    localparam int unsigned DW  = 8;
    localparam int unsigned AW  = 2;
    localparam logic [AW-1:0] CTL_ADDR = 2'b11;
    localparam logic [1:0]    SEL_RB   = 2'b11;
    localparam logic [1:0]    FMT_SNAP = 2'b00;

    typedef logic [NCH-1:0] chvec_t;

    typedef struct packed {
        chvec_t          mode_wr;
        chvec_t          cnt_wr;
        chvec_t          latch_cnt;
        chvec_t          latch_sts;
        chvec_t          rd_done;
        logic [1:0]      fmt;
        logic [2:0]      mode;
        logic            bcd;
        logic [DW-1:0]   wbyte;
    } cmd_t;

    // R6: codes with a don't-care top bit collapse onto 010 and 011
    function automatic logic [2:0] fold_mode(input logic [2:0] m);
        return m[1] ? {1'b0, m[1:0]} : m;
    endfunction

    function automatic chvec_t ch_onehot(input logic [AW-1:0] a);
        chvec_t v;
        v = '0;
        for (int i = 0; i < NCH; i++)
            if (a == AW'(i)) v[i] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/tmr_edge_cap.sv
module tmr_edge_cap #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         active,
    input  logic [W-1:0] din,
    output logic         fire,
    output logic [W-1:0] cap
);
    logic         act_q;
    logic [W-1:0] cap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= 1'b0;
            cap_q <= '0;
        end else begin
            act_q <= active;
            if (active) cap_q <= din;
        end
    end

    // trailing edge of the qualified strobe
    assign fire = act_q & ~active;
    assign cap  = cap_q;
endmodule

// File: rtl/tmr_cmd_decode.sv
module tmr_cmd_decode
    import tmr_bus_pkg::*;
(
    input  logic              wr_fire,
    input  logic [AW-1:0]     waddr,
    input  logic [DW-1:0]     wdata,
    input  logic              rd_fire,
    input  logic [AW-1:0]     raddr,
    output cmd_t              cmd
);
    logic [1:0] sel;
    logic [1:0] fmt;
    chvec_t     rb_sel;

    assign sel    = wdata[7:6];
    assign fmt    = wdata[5:4];
    assign rb_sel = wdata[NCH:1];

    always_comb begin
        cmd       = '0;
        cmd.fmt   = fmt;
        cmd.mode  = fold_mode(wdata[3:1]);
        cmd.bcd   = wdata[0];
        cmd.wbyte = wdata;
        if (wr_fire) begin
            if (waddr != CTL_ADDR) begin
                // R1
                cmd.cnt_wr = ch_onehot(waddr);
            end else if (sel != SEL_RB) begin
                if (fmt == FMT_SNAP) cmd.latch_cnt = ch_onehot(sel); // R7
                else                 cmd.mode_wr   = ch_onehot(sel); // R5
            end else begin
                // R8: multi-channel read-back, active-low request bits
                if (!wdata[5]) cmd.latch_cnt = rb_sel;
                if (!wdata[4]) cmd.latch_sts = rb_sel;
            end
        end
        // R10
        if (rd_fire && raddr != CTL_ADDR) cmd.rd_done = ch_onehot(raddr);
    end
endmodule

// File: rtl/tmr_rd_mux.sv
module tmr_rd_mux
    import tmr_bus_pkg::*;
(
    input  logic [AW-1:0]     addr,
    input  logic [NCH*DW-1:0] ch_rdata,
    output logic [DW-1:0]     rbyte,
    output logic              hit
);
    logic [DW-1:0] part [NCH];
    chvec_t        sel;

    assign sel = ch_onehot(addr);

    for (genvar g = 0; g < NCH; g++) begin : g_lane
        assign part[g] = sel[g] ? ch_rdata[g*DW +: DW] : '0;
    end

    always_comb begin
        rbyte = '0;
        for (int i = 0; i < NCH; i++) rbyte |= part[i];
    end

    assign hit = |sel;
endmodule

// File: rtl/tmr_bus_front.sv
module tmr_bus_front
    import tmr_bus_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cs_n,
    input  logic                 rd_n,
    input  logic                 wr_n,
    input  logic [1:0]           addr,
    input  logic [7:0]           bus_in,
    output logic [7:0]           bus_out,
    output logic                 bus_oe,
    input  logic [23:0]          ch_rdata,
    output logic [2:0]           mode_wr,
    output logic [1:0]           mode_fmt,
    output logic [2:0]           mode_code,
    output logic                 mode_bcd,
    output logic [2:0]           cnt_wr,
    output logic [7:0]           cnt_byte,
    output logic [2:0]           latch_cnt,
    output logic [2:0]           latch_sts,
    output logic [2:0]           rd_done
);
    localparam int unsigned WCAP = AW + DW;

    // R2, R4: strobes count only when selected and not both asserted
    logic wr_act, rd_act;
    assign wr_act = ~cs_n & ~wr_n &  rd_n;
    assign rd_act = ~cs_n & ~rd_n &  wr_n;

    logic            wr_fire, rd_fire;
    logic [WCAP-1:0] wcap;
    logic [AW-1:0]   rcap;

    tmr_edge_cap #(.W(WCAP)) u_wcap (
        .clk(clk), .rst(rst), .active(wr_act),
        .din({addr, bus_in}), .fire(wr_fire), .cap(wcap)
    );

    tmr_edge_cap #(.W(AW)) u_rcap (
        .clk(clk), .rst(rst), .active(rd_act),
        .din(addr), .fire(rd_fire), .cap(rcap)
    );

    cmd_t cmd_d, cmd_q;

    tmr_cmd_decode u_dec (
        .wr_fire(wr_fire), .waddr(wcap[WCAP-1 -: AW]), .wdata(wcap[DW-1:0]),
        .rd_fire(rd_fire), .raddr(rcap), .cmd(cmd_d)
    );

    // R9, R11: one registered strobe cycle, cleared by reset
    always_ff @(posedge clk) begin
        if (rst) cmd_q <= '0;
        else     cmd_q <= cmd_d;
    end

    logic [DW-1:0] rbyte;
    logic          rhit;

    // R3: unregistered read path
    tmr_rd_mux u_mux (.addr(addr), .ch_rdata(ch_rdata), .rbyte(rbyte), .hit(rhit));

    assign bus_oe    = rd_act & rhit;
    assign bus_out   = rbyte;
    assign mode_wr   = cmd_q.mode_wr;
    assign mode_fmt  = cmd_q.fmt;
    assign mode_code = cmd_q.mode;
    assign mode_bcd  = cmd_q.bcd;
    assign cnt_wr    = cmd_q.cnt_wr;
    assign cnt_byte  = cmd_q.wbyte;
    assign latch_cnt = cmd_q.latch_cnt;
    assign latch_sts = cmd_q.latch_sts;
    assign rd_done   = cmd_q.rd_done;
endmodule

// File: rtl/tmr_bus_front_chk.sv
module tmr_bus_front_chk (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       rd_n,
    input logic       wr_n,
    input logic [1:0] addr,
    input logic       bus_oe,
    input logic [2:0] mode_wr,
    input logic [2:0] mode_code,
    input logic [2:0] cnt_wr,
    input logic [2:0] latch_cnt,
    input logic [2:0] latch_sts,
    input logic [2:0] rd_done
);
    // R1
    cnt_wr_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cnt_wr));

    // R2
    cs_idle_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !bus_oe);

    // R3
    ctl_read_chk: assert property (@(posedge clk) disable iff (rst)
        (addr == 2'b11) |-> !bus_oe);

    // R4
    both_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_n && !wr_n) |-> !bus_oe);

    // R5
    mode_wr_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(mode_wr));

    // R6
    mode_fold_chk: assert property (@(posedge clk) disable iff (rst)
        (|mode_wr) |-> !(mode_code[2] && mode_code[1]));

    // R7
    latch_excl_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_wr & latch_cnt) == 3'b000);

    // R8
    sts_alone_chk: assert property (@(posedge clk) disable iff (rst)
        (|latch_sts) |-> (mode_wr == 3'b000 && cnt_wr == 3'b000));

    // R9
    pulse_once_chk: assert property (@(posedge clk) disable iff (rst)
        (|cnt_wr) |=> (cnt_wr == 3'b000));

    // R10
    rd_done_chk: assert property (@(posedge clk) disable iff (rst)
        (|rd_done) |-> $past(!cs_n && !rd_n && wr_n, 2));

    // R11
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mode_wr == 3'b000 && cnt_wr == 3'b000 && rd_done == 3'b000));
endmodule

bind tmr_bus_front tmr_bus_front_chk chk_i (.*);

// File: tb/tmr_bus_front_tb_top.sv
module tmr_bus_front_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0]  addr = 2'b00;
    logic [7:0]  bus_in = 8'h00;
    logic [23:0] ch_rdata = 24'h3C_B5_96;
    logic [7:0]  bus_out;
    logic        bus_oe;
    logic [2:0]  mode_wr, mode_code, cnt_wr, latch_cnt, latch_sts, rd_done;
    logic [1:0]  mode_fmt;
    logic        mode_bcd;
    logic [7:0]  cnt_byte;

    tmr_bus_front dut_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .ch_rdata(ch_rdata), .mode_wr(mode_wr), .mode_fmt(mode_fmt),
        .mode_code(mode_code), .mode_bcd(mode_bcd), .cnt_wr(cnt_wr),
        .cnt_byte(cnt_byte), .latch_cnt(latch_cnt), .latch_sts(latch_sts),
        .rd_done(rd_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    checks = 0, failures = 0, cycles = 0;
    bit    started = 0;
    string ctx = "R11";

    // behavioural reference state
    bit         m_wa = 0, m_ra = 0;
    int         m_wad = 0, m_rad = 0;
    logic [7:0] m_wd = 0;
    logic [2:0] e_mode = 0, e_cnt = 0, e_lc = 0, e_ls = 0, e_rd = 0;
    logic [1:0] e_fmt = 0;
    int         e_code = 0;
    logic       e_bcd = 0;
    logic [7:0] e_byte = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s [%s] actual=%0h expected=%0h at %0t", req, ctx, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        bit wa, ra;
        int s;
        wa = !cs_n && !wr_n && rd_n;
        ra = !cs_n && !rd_n && wr_n;
        started = 1;
        e_mode = 0; e_cnt = 0; e_lc = 0; e_ls = 0; e_rd = 0;
        if (rst) begin
            m_wa = 0; m_ra = 0;
        end else begin
            if (m_wa && !wa) begin
                if (m_wad != 3) begin
                    e_cnt[m_wad] = 1'b1;
                    e_byte = m_wd;
                end else begin
                    s = int'(m_wd[7:6]);
                    if (s != 3) begin
                        if (m_wd[5:4] == 2'b00) e_lc[s] = 1'b1;
                        else begin
                            e_mode[s] = 1'b1;
                            e_fmt = m_wd[5:4];
                            e_code = int'(m_wd[3:1]);
                            if (e_code >= 6) e_code -= 4;
                            e_bcd = m_wd[0];
                        end
                    end else begin
                        for (int i = 0; i < 3; i++) begin
                            if (m_wd[i+1]) begin
                                if (!m_wd[5]) e_lc[i] = 1'b1;
                                if (!m_wd[4]) e_ls[i] = 1'b1;
                            end
                        end
                    end
                end
            end
            if (m_ra && !ra && m_rad != 3) e_rd[m_rad] = 1'b1;
            m_wa = wa; m_ra = ra;
            if (wa) begin m_wad = int'(addr); m_wd = bus_in; end
            if (ra) m_rad = int'(addr);
        end
    end

    always @(negedge clk) begin
        bit eo;
        cycles++;
        if (started) begin
            eo = !cs_n && !rd_n && wr_n && addr != 2'b11;
            if (rst) chk(cnt_wr === 0 && mode_wr === 0 && latch_cnt === 0 &&
                         latch_sts === 0 && rd_done === 0, "R11", int'(cnt_wr), 0);
            chk(bus_oe === eo, "R3 bus_oe", int'(bus_oe), int'(eo));
            if (eo) chk(bus_out === ch_rdata[addr*8 +: 8], "R3 bus_out",
                        int'(bus_out), int'(ch_rdata[addr*8 +: 8]));
            chk(cnt_wr === e_cnt, "R1 cnt_wr", int'(cnt_wr), int'(e_cnt));
            if (|e_cnt) chk(cnt_byte === e_byte, "R1 cnt_byte", int'(cnt_byte), int'(e_byte));
            chk(mode_wr === e_mode, "R5 mode_wr", int'(mode_wr), int'(e_mode));
            if (|e_mode) begin
                chk(mode_fmt === e_fmt && mode_bcd === e_bcd, "R5 fields",
                    int'({mode_fmt, mode_bcd}), int'({e_fmt, e_bcd}));
                chk(int'(mode_code) == e_code, "R6 mode_code", int'(mode_code), e_code);
            end
            chk(latch_cnt === e_lc, "R7 latch_cnt", int'(latch_cnt), int'(e_lc));
            chk(latch_sts === e_ls, "R8 latch_sts", int'(latch_sts), int'(e_ls));
            chk(rd_done === e_rd, "R10 rd_done", int'(rd_done), int'(e_rd));
        end
        if (cycles > WATCHDOG) begin
            checks++; failures++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic bus_op(input logic c, input logic r, input logic w,
                          input logic [1:0] a, input logic [7:0] d, input int hold);
        @(negedge clk);
        #1;
        cs_n = c; rd_n = r; wr_n = w; addr = a; bus_in = d;
        repeat (hold) @(negedge clk);
        #1;
        cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        ctx = "R11";
        repeat (4) @(negedge clk);
        #1; rst = 1'b0;
        repeat (2) @(negedge clk);

        ctx = "R1";
        bus_op(0, 1, 0, 2'd0, 8'h5A, 2);
        bus_op(0, 1, 0, 2'd1, 8'hC3, 1);
        bus_op(0, 1, 0, 2'd2, 8'h01, 3);
        ctx = "R9";
        bus_op(0, 1, 0, 2'd2, 8'hFF, 6);
        ctx = "R5";
        bus_op(0, 1, 0, 2'd3, 8'b01_11_110_1, 2);
        bus_op(0, 1, 0, 2'd3, 8'b00_01_011_0, 2);
        bus_op(0, 1, 0, 2'd3, 8'b10_10_100_1, 2);
        ctx = "R6";
        bus_op(0, 1, 0, 2'd3, 8'b00_11_111_0, 2);
        ctx = "R7";
        bus_op(0, 1, 0, 2'd3, 8'b10_00_101_1, 2);
        ctx = "R8";
        bus_op(0, 1, 0, 2'd3, 8'b11_00_111_0, 2);
        bus_op(0, 1, 0, 2'd3, 8'b11_10_010_1, 2);
        bus_op(0, 1, 0, 2'd3, 8'b11_01_101_0, 2);
        bus_op(0, 1, 0, 2'd3, 8'b11_11_111_0, 2);
        ctx = "R2";
        bus_op(1, 1, 0, 2'd0, 8'h77, 3);
        bus_op(1, 0, 1, 2'd1, 8'h00, 3);
        ctx = "R4";
        bus_op(0, 0, 0, 2'd1, 8'h44, 3);
        bus_op(0, 1, 1, 2'd2, 8'h44, 3);
        ctx = "R3";
        bus_op(0, 0, 1, 2'd0, 8'h00, 2);
        bus_op(0, 0, 1, 2'd1, 8'h00, 1);
        bus_op(0, 0, 1, 2'd2, 8'h00, 3);
        ch_rdata = 24'h12_EF_08;
        bus_op(0, 0, 1, 2'd2, 8'h00, 2);
        ctx = "R10";
        bus_op(0, 0, 1, 2'd3, 8'h00, 2);
        bus_op(0, 0, 1, 2'd0, 8'h00, 2);
        ctx = "R11";
        @(negedge clk); #1;
        cs_n = 1'b0; wr_n = 1'b0; addr = 2'd1; bus_in = 8'h99;
        @(negedge clk); #1;
        rst = 1'b1; cs_n = 1'b1; wr_n = 1'b1;
        repeat (3) @(negedge clk);
        #1; rst = 1'b0;
        repeat (4) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule